// File: doc/BRIEF.md
# Four-Channel Double-Buffered Analog-Output Register Interface

This block sits between a 16-bit register bus and four analog-output converters. Each of the four channels has a staging register that takes a 12-bit code from a bus write. A shared staging register holds a polarity bit and a gain bit for every channel. The block drives the active code, polarity and gain of each channel to the converters, which are outside this block.

Changes are committed by bus *reads* of two dedicated addresses. A read of the control-update address copies the staged polarity and gain bits into the active outputs. A read of the data-update address copies all four staged codes at once, so every channel changes on the same clock. A global control register has two bits. The enable bit forces every active code to mid-scale while it is clear. The buffered bit chooses whether a data write applies at once or waits for the data-update read.

Top module: `dac_quad_if`

## Requirements
- R1: After synchronous reset every active code is 0x800, every polarity and gain output is 0, the global control register is clear (disabled, unbuffered) and the staged codes are 0.
- R2: A write to byte address 0x14 + 2*n stages a code for channel n (0 = A ... 3 = D) and for no other channel. Only wdata[11:0] is kept and the upper four bits are dropped. A write to an address that no register decodes changes nothing.
- R3: While enabled and buffered, a data write leaves the active codes unchanged. A read of address 0x02 copies all four staged codes into the active codes on the clock edge that samples the read.
- R4: While enabled and unbuffered, a data write to channel n sets that channel's active code to wdata[11:0] on the clock edge that samples the write.
- R5: While the enable bit is clear, every active code is 0x800 from the next clock on, and reads of 0x02 have no effect.
- R6: A write to address 0x12 only stages the control value. The active polarity and gain outputs change only on a read of 0x12 while enabled.
- R7: In the control value, bit 7-n is channel n's polarity (1 = bipolar) and bit 11-n is channel n's gain select. All other bits are ignored.
- R8: A read of 0x12 while disabled leaves the active polarity and gain outputs unchanged.
- R9: In the global control register at 0x02, bit 1 enables the outputs and bit 0 selects buffered mode. Writing zero to 0x02 disables the block. Writing zero to 0x12 and then committing it clears all polarity and gain outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, used only as a commit trigger |
| bus_addr | input | ADDR_W (8) | Byte address of the access |
| bus_wdata | input | BUS_W (16) | Write data |
| ch_code | output | N_CH*CODE_W (48) | Active codes, channel 0 in the low 12 bits |
| ch_bipolar | output | N_CH (4) | Active polarity per channel, 1 = bipolar |
| ch_gain | output | N_CH (4) | Active gain select per channel |

## Verification
The hardest state to reach is one where the staged and active values differ on every channel at once. Only then does a single data-update read show that all four channels move on the same edge. Only then does a commit attempted while disabled show that it was dropped. The bench switches to buffered mode and writes a different code to each channel. It checks that nothing moved, then commits. It also sweeps all 256 polarity and gain patterns, checking the active outputs both before and after each commit read, and it repeats the commit attempts with the enable bit cleared.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

  // Global control register fields (bit 1 enable, bit 0 buffered).
  typedef struct packed {
    logic enable;
    logic buffered;
  } gctrl_t;

  localparam int unsigned GCTRL_W = $bits(gctrl_t);

endpackage

// File: rtl/dacif_decode.sv
module dacif_decode #(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned N_CH       = 4,
  parameter logic [7:0]  GCTRL_ADDR = 8'h02,
  parameter logic [7:0]  DCTRL_ADDR = 8'h12,
  parameter logic [7:0]  DATA_BASE  = 8'h14
) (
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              gctrl_we,
  output logic              dctrl_we,
  output logic              dctrl_commit,
  output logic              data_commit,
  output logic [N_CH-1:0]   data_we
);

  localparam logic [ADDR_W-1:0] G_A = ADDR_W'(GCTRL_ADDR);
  localparam logic [ADDR_W-1:0] D_A = ADDR_W'(DCTRL_ADDR);

  always_comb begin
    gctrl_we     = bus_wr && (bus_addr == G_A);
    dctrl_we     = bus_wr && (bus_addr == D_A);
    data_commit  = bus_rd && (bus_addr == G_A);
    dctrl_commit = bus_rd && (bus_addr == D_A);
  end

  for (genvar n = 0; n < N_CH; n++) begin : g_data_hit
    localparam logic [ADDR_W-1:0] CH_A = ADDR_W'(DATA_BASE + 2 * n);
    assign data_we[n] = bus_wr && (bus_addr == CH_A);
  end

endmodule

// File: rtl/dacif_ctrl.sv
module dacif_ctrl
  import dacif_pkg::*;
#(
  parameter int unsigned BUS_W    = 16,
  parameter int unsigned N_CH     = 4,
  parameter int unsigned POL_TOP  = 7,
  parameter int unsigned GAIN_TOP = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gctrl_we,
  input  logic             dctrl_we,
  input  logic             dctrl_commit,
  input  logic [BUS_W-1:0] wdata,
  output logic             enable,
  output logic             buffered,
  output logic [N_CH-1:0]  pol_act,
  output logic [N_CH-1:0]  gain_act
);

  gctrl_t           gctrl_q;
  logic [BUS_W-1:0] dctrl_stage;
  logic [N_CH-1:0]  pol_stage;
  logic [N_CH-1:0]  gain_stage;

  always_ff @(posedge clk) begin
    if (rst) begin
      gctrl_q     <= '0;
      dctrl_stage <= '0;
    end else begin
      if (gctrl_we)
        gctrl_q <= gctrl_t'(wdata[GCTRL_W-1:0]);
      if (dctrl_we)
        dctrl_stage <= wdata;
    end
  end

  // Descending layout: channel n sits n places right of channel 0.
  for (genvar n = 0; n < N_CH; n++) begin : g_field
    assign pol_stage[n]  = dctrl_stage[POL_TOP - n];
    assign gain_stage[n] = dctrl_stage[GAIN_TOP - n];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_act  <= '0;
      gain_act <= '0;
    end else if (dctrl_commit && gctrl_q.enable) begin
      pol_act  <= pol_stage;
      gain_act <= gain_stage;
    end
  end

  assign enable   = gctrl_q.enable;
  assign buffered = gctrl_q.buffered;

  assert_ctrl_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !dctrl_commit |=> $stable(pol_act) && $stable(gain_act));

  assert_ctrl_off_R8: assert property (@(posedge clk) disable iff (rst)
    !enable |=> $stable(pol_act) && $stable(gain_act));

endmodule

// File: rtl/dacif_channel.sv
module dacif_channel #(
  parameter int unsigned BUS_W  = 16,
  parameter int unsigned CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              buffered,
  input  logic              we,
  input  logic              commit,
  input  logic [BUS_W-1:0]  wdata,
  output logic [CODE_W-1:0] code_act
);

  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

  logic [CODE_W-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q  <= '0;
      code_act <= MID;
    end else begin
      if (we)
        stage_q <= wdata[CODE_W-1:0];
      if (!enable)
        code_act <= MID;
      else if (!buffered && we)
        code_act <= wdata[CODE_W-1:0];
      else if (commit)
        code_act <= stage_q;
    end
  end

  assert_mid_when_off_R5: assert property (@(posedge clk) disable iff (rst)
    !enable |=> code_act == MID);

  assert_buffered_hold_R3: assert property (@(posedge clk) disable iff (rst)
    enable && buffered && !commit |=> $stable(code_act));

  assert_direct_write_R4: assert property (@(posedge clk) disable iff (rst)
    enable && !buffered && we |=> code_act == $past(wdata[CODE_W-1:0]));

endmodule

// File: rtl/dac_quad_if.sv
module dac_quad_if #(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned BUS_W      = 16,
  parameter int unsigned CODE_W     = 12,
  parameter int unsigned N_CH       = 4,
  parameter logic [7:0]  GCTRL_ADDR = 8'h02,
  parameter logic [7:0]  DCTRL_ADDR = 8'h12,
  parameter logic [7:0]  DATA_BASE  = 8'h14,
  parameter int unsigned POL_TOP    = 7,
  parameter int unsigned GAIN_TOP   = 11
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [BUS_W-1:0]       bus_wdata,
  output logic [N_CH*CODE_W-1:0] ch_code,
  output logic [N_CH-1:0]        ch_bipolar,
  output logic [N_CH-1:0]        ch_gain
);

  logic            gctrl_we;
  logic            dctrl_we;
  logic            dctrl_commit;
  logic            data_commit;
  logic [N_CH-1:0] data_we;
  logic            enable;
  logic            buffered;

  dacif_decode #(
    .ADDR_W(ADDR_W), .N_CH(N_CH), .GCTRL_ADDR(GCTRL_ADDR),
    .DCTRL_ADDR(DCTRL_ADDR), .DATA_BASE(DATA_BASE)
  ) u_decode (
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .gctrl_we(gctrl_we), .dctrl_we(dctrl_we), .dctrl_commit(dctrl_commit),
    .data_commit(data_commit), .data_we(data_we)
  );

  dacif_ctrl #(
    .BUS_W(BUS_W), .N_CH(N_CH), .POL_TOP(POL_TOP), .GAIN_TOP(GAIN_TOP)
  ) u_ctrl (
    .clk(clk), .rst(rst), .gctrl_we(gctrl_we), .dctrl_we(dctrl_we),
    .dctrl_commit(dctrl_commit), .wdata(bus_wdata),
    .enable(enable), .buffered(buffered),
    .pol_act(ch_bipolar), .gain_act(ch_gain)
  );

  for (genvar n = 0; n < N_CH; n++) begin : g_chan
    dacif_channel #(.BUS_W(BUS_W), .CODE_W(CODE_W)) u_chan (
      .clk(clk), .rst(rst), .enable(enable), .buffered(buffered),
      .we(data_we[n]), .commit(data_commit), .wdata(bus_wdata),
      .code_act(ch_code[n*CODE_W +: CODE_W])
    );
  end

  assert_one_channel_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(data_we));

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> ch_bipolar == '0 && ch_gain == '0);

endmodule

// File: tb/dac_quad_if_test.sv
module dac_quad_if_test;

  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [15:0]   bus_wdata = '0;
  logic [NC*CW-1:0] ch_code;
  logic [NC-1:0] ch_bipolar;
  logic [NC-1:0] ch_gain;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [CW-1:0] m_stage [NC];
  logic [CW-1:0] m_act   [NC];
  logic [NC-1:0] m_pol;
  logic [NC-1:0] m_gain;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_quad_if uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .ch_code(ch_code), .ch_bipolar(ch_bipolar), .ch_gain(ch_gain)
  );

  task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic check_all(input string req);
    logic [NC*CW-1:0] exp_code;
    for (int n = 0; n < NC; n++) exp_code[n*CW +: CW] = m_act[n];
    checks++;
    if (ch_code !== exp_code || ch_bipolar !== m_pol || ch_gain !== m_gain) begin
      fails++;
      $display("FAIL %s: code=%h pol=%b gain=%b expected code=%h pol=%b gain=%b",
               req, ch_code, ch_bipolar, ch_gain, exp_code, m_pol, m_gain);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] vals [7];
    vals = '{16'h0000, 16'h0001, 16'h07FF, 16'h0800, 16'h0FFF, 16'hA5C3, 16'hF000};
    for (int n = 0; n < NC; n++) begin m_stage[n] = '0; m_act[n] = 12'h800; end
    m_pol = '0; m_gain = '0;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle();
    check_all("R1 reset state");

    // Disabled: staging works, commits ignored, codes mid-scale.
    for (int n = 0; n < NC; n++) begin
      bus_write(8'h14 + 8'(2*n), 16'h0100 + 16'(n));
      m_stage[n] = 12'h100 + 12'(n);
    end
    bus_read(8'h02);
    check_all("R5 data commit ignored while disabled");
    bus_write(8'h12, 16'h0FF0);
    bus_read(8'h12);
    check_all("R8 control commit ignored while disabled");

    // Enable, unbuffered (R9 bit1 enable, bit0 buffered).
    bus_write(8'h02, 16'h0002);
    idle();
    check_all("R9 enable keeps codes until written");
    for (int n = 0; n < NC; n++) begin
      for (int v = 0; v < 7; v++) begin
        bus_write(8'h14 + 8'(2*n), vals[v]);
        m_stage[n] = vals[v][11:0];
        m_act[n]   = vals[v][11:0];
        check_all("R4 R2 direct write and upper bits dropped");
      end
    end

    // Buffered mode: stage distinct codes, nothing moves until commit.
    bus_write(8'h02, 16'h0003);
    for (int r = 0; r < 4; r++) begin
      for (int n = 0; n < NC; n++) begin
        logic [15:0] d;
        d = 16'h3000 + 16'(r*16'h0111) + 16'(n*16'h0040) + 16'h0005;
        bus_write(8'h14 + 8'(2*n), d);
        m_stage[n] = d[11:0];
        check_all("R3 buffered write holds active code");
      end
      bus_write(8'h1C, 16'hFFFF);
      bus_write(8'h00, 16'hFFFF);
      bus_read(8'h02);
      for (int n = 0; n < NC; n++) m_act[n] = m_stage[n];
      check_all("R3 R2 simultaneous commit, stray addresses ignored");
    end

    // Sweep all polarity and gain patterns.
    for (int p = 0; p < 256; p++) begin
      logic [15:0] d;
      d = {4'hA, 4'(p >> 4), 4'(p), 4'hF};
      bus_write(8'h12, d);
      check_all("R6 control write only stages");
      bus_read(8'h12);
      for (int n = 0; n < NC; n++) begin
        m_pol[n]  = d[7 - n];
        m_gain[n] = d[11 - n];
      end
      check_all("R7 polarity and gain bit positions");
    end

    // Software clear and disabled commit.
    bus_write(8'h12, 16'h0000);
    bus_read(8'h12);
    m_pol = '0; m_gain = '0;
    check_all("R9 zero control clears polarity and gain");
    bus_write(8'h12, 16'h0FF0);
    bus_write(8'h02, 16'h0000);
    idle();
    for (int n = 0; n < NC; n++) m_act[n] = 12'h800;
    check_all("R9 R5 zero global control forces mid-scale");
    bus_read(8'h12);
    bus_read(8'h02);
    check_all("R8 R5 commits ignored after disable");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule